// File: doc/BRIEF.md
# PCI Target Error Response Controller

This block decides how a PCI target ends each transaction and how it reports faults. It watches three kinds of error: a data parity error seen during a data phase, an address parity error seen during an address phase, and an invalid local access flagged by an address range monitor. From these it drives a sticky parity-error status bit, a PERR# strobe, a SERR# strobe, a target-abort request, a start request for the local bus, and a discard command for the posted-write queue.

Reads are either immediate or delayed. When a delayed read hits an invalid range, the abort is not signalled at once. The block keeps a pending-abort flag for that delayed-read slot and delivers the abort when the master retries. Writes are posted. The queue logic breaks each posted write into local segments and reports the outcome of each one. A bad segment drops whatever data of that write is still queued and may raise a one-clock SERR#. Because of this, a single posted write can produce several SERR# pulses. Every output is registered and appears one clock after its cause.

Top module: `pci_terr_ctrl`

## Requirements
- R1: A data parity strobe sets `pe_status` on the next clock. The bit then stays set while the inputs are idle.
- R2: A data parity strobe gives a one-clock `perr_pulse` on the next clock only when `cmd_pen` is 1. With `cmd_pen` at 0 the pulse stays low but `pe_status` is still set.
- R3: `pe_wr1c` clears `pe_status` on the next clock. If a data parity strobe arrives in the same cycle, the set wins.
- R4: An address phase with `adr_par_err` high gives `tgt_abort` on the next clock and no `local_start`. This holds for reads, writes and retries alike.
- R5: An immediate read (`adr_write`=0, `adr_delayed`=0, `adr_retry`=0) with `rng_bad` gives `tgt_abort` on the next clock and no `local_start`.
- R6: A delayed read (`adr_delayed`=1) with `rng_bad` gives neither an abort nor a start. It sets the pending flag of `adr_slot`. A later retry of that slot gives `tgt_abort` on the next clock and clears the flag, so a second retry of the slot is not aborted.
- R7: A retry (`adr_retry`=1) of a slot with no pending flag gives neither `tgt_abort` nor `local_start`.
- R8: A clean non-retry address phase gives a one-clock `local_start` on the next clock and no abort. For writes, `rng_bad` has no effect at the address phase.
- R9: A segment reported bad (`seg_vld` and `seg_bad`) gives a one-clock `serr_pulse` on the next clock only when both `cmd_sen` and `cmd_pen` are 1.
- R10: A bad segment that is not the last segment of its write (`seg_last`=0) gives `queue_discard` on the next clock. A bad last segment gives no discard.
- R11: Each bad segment of the same posted write raises its own `serr_pulse`, including on back-to-back cycles.
- R12: While `rst` is high, all outputs are 0 and all pending-abort flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_pen | input | 1 | Parity error response enable (command register) |
| cmd_sen | input | 1 | System error enable (command register) |
| pe_wr1c | input | 1 | Software write-one-to-clear of the parity status bit |
| dpar_err | input | 1 | Data parity error detected |
| adr_vld | input | 1 | Address phase qualifier |
| adr_write | input | 1 | 1 = write (posted), 0 = read |
| adr_delayed | input | 1 | Read is handled as a delayed read |
| adr_retry | input | 1 | Address phase is a retry of a delayed read |
| adr_slot | input | SLOT_W | Delayed-read slot index |
| adr_par_err | input | 1 | Address parity error detected |
| rng_bad | input | 1 | Range monitor flags the read address as invalid |
| seg_vld | input | 1 | A posted-write segment outcome is reported |
| seg_bad | input | 1 | That segment hit an undecoded address |
| seg_last | input | 1 | That segment is the last one of its write |
| pe_status | output | 1 | Sticky parity error status |
| perr_pulse | output | 1 | PERR# strobe (active high) |
| serr_pulse | output | 1 | SERR# strobe (active high) |
| tgt_abort | output | 1 | Terminate the current transaction with target abort |
| local_start | output | 1 | Start a local bus transaction |
| queue_discard | output | 1 | Flush the rest of the current posted write |

## Verification
Every result of this block is due exactly one clock after the cycle that caused it. This covers status set and clear, strobes, abort, start and discard. Inputs change on the falling edge. The driver works out the whole expected output word for the following rising edge from its own model of the pending flags and the status bit, and queues it. The monitor takes one word off the queue one nanosecond after each rising edge and compares it against the outputs. Idle cycles are also queued and compared, so a pulse that lasts too long or shows up late is caught too.

// File: rtl/pci_terr_pkg.sv
package pci_terr_pkg;

  // Qualifiers of one PCI address phase as seen by the error controller.
  typedef struct packed {
    logic vld;
    logic write;
    logic delayed;
    logic retry;
    logic par_err;
    logic rng_bad;
  } adr_phase_t;

endpackage

// File: rtl/pci_terr_parity.sv
module pci_terr_parity (
  input  logic clk,
  input  logic rst,
  input  logic pen,
  input  logic dpe,
  input  logic pe_clr,
  output logic pe_q,
  output logic perr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_q   <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      perr_q <= dpe & pen;
      if (dpe)
        pe_q <= 1'b1;
      else if (pe_clr)
        pe_q <= 1'b0;
    end
  end

  // PERR# never fires without the status bit being recorded
  p_perr_implies_pe_r1: assert property (@(posedge clk) disable iff (rst)
    perr_q |-> pe_q);

  // a clear with no competing set empties the status bit
  p_clear_takes_r3: assert property (@(posedge clk) disable iff (rst)
    (pe_clr && !dpe) |=> !pe_q);

endmodule

// File: rtl/pci_terr_adr.sv
module pci_terr_adr
  import pci_terr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  adr_phase_t        ph,
  input  logic [SLOT_W-1:0] slot,
  output logic              abort_q,
  output logic              start_q
);

  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] set_v, clr_v;
  logic abort_n, start_n, do_set, do_clr, hit;

  assign hit = pend_q[slot];

  always_comb begin
    abort_n = 1'b0;
    start_n = 1'b0;
    do_set  = 1'b0;
    do_clr  = 1'b0;
    if (ph.vld) begin
      if (ph.par_err) begin
        abort_n = 1'b1;
      end else if (ph.retry) begin
        if (hit) begin
          abort_n = 1'b1;
          do_clr  = 1'b1;
        end
      end else if (!ph.write && ph.rng_bad) begin
        if (ph.delayed) do_set  = 1'b1;
        else            abort_n = 1'b1;
      end else begin
        start_n = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_dec
    assign set_v[i] = do_set && (slot == SLOT_W'(i));
    assign clr_v[i] = do_clr && (slot == SLOT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      abort_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      abort_q <= abort_n;
      start_q <= start_n;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (set_v[i])      pend_q[i] <= 1'b1;
        else if (clr_v[i]) pend_q[i] <= 1'b0;
      end
    end
  end

  // a delivered retry abort consumes the slot's pending flag
  p_retry_consumes_r6: assert property (@(posedge clk) disable iff (rst)
    (ph.vld && ph.retry && !ph.par_err && pend_q[slot]) |=> !pend_q[$past(slot)]);

  // a delayed read with a bad range never aborts immediately
  p_delayed_defers_r6: assert property (@(posedge clk) disable iff (rst)
    (ph.vld && !ph.par_err && !ph.retry && !ph.write && ph.delayed && ph.rng_bad)
      |=> (!abort_q && !start_q));

endmodule

// File: rtl/pci_terr_pwseg.sv
module pci_terr_pwseg (
  input  logic clk,
  input  logic rst,
  input  logic pen,
  input  logic sen,
  input  logic seg_vld,
  input  logic seg_bad,
  input  logic seg_last,
  output logic serr_q,
  output logic disc_q
);

  logic seg_err;
  assign seg_err = seg_vld & seg_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      serr_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      serr_q <= seg_err & sen & pen;
      disc_q <= seg_err & ~seg_last;
    end
  end

  // a SERR# from a non-final segment always comes with a flush
  p_serr_with_flush_r10: assert property (@(posedge clk) disable iff (rst)
    (seg_err && !seg_last && sen && pen) |=> (serr_q && disc_q));

  // each bad segment gives its own pulse, even back to back
  p_pulse_per_segment_r11: assert property (@(posedge clk) disable iff (rst)
    (serr_q && seg_err && sen && pen) |=> serr_q);

endmodule

// File: rtl/pci_terr_ctrl.sv
module pci_terr_ctrl
  import pci_terr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_pen,
  input  logic              cmd_sen,
  input  logic              pe_wr1c,
  input  logic              dpar_err,
  input  logic              adr_vld,
  input  logic              adr_write,
  input  logic              adr_delayed,
  input  logic              adr_retry,
  input  logic [SLOT_W-1:0] adr_slot,
  input  logic              adr_par_err,
  input  logic              rng_bad,
  input  logic              seg_vld,
  input  logic              seg_bad,
  input  logic              seg_last,
  output logic              pe_status,
  output logic              perr_pulse,
  output logic              serr_pulse,
  output logic              tgt_abort,
  output logic              local_start,
  output logic              queue_discard
);

  adr_phase_t ph;
  assign ph = '{vld: adr_vld, write: adr_write, delayed: adr_delayed,
                retry: adr_retry, par_err: adr_par_err, rng_bad: rng_bad};

  pci_terr_parity u_parity (
    .clk(clk), .rst(rst), .pen(cmd_pen), .dpe(dpar_err), .pe_clr(pe_wr1c),
    .pe_q(pe_status), .perr_q(perr_pulse)
  );

  pci_terr_adr #(.NUM_SLOTS(NUM_SLOTS)) u_adr (
    .clk(clk), .rst(rst), .ph(ph), .slot(adr_slot),
    .abort_q(tgt_abort), .start_q(local_start)
  );

  pci_terr_pwseg u_pwseg (
    .clk(clk), .rst(rst), .pen(cmd_pen), .sen(cmd_sen),
    .seg_vld(seg_vld), .seg_bad(seg_bad), .seg_last(seg_last),
    .serr_q(serr_pulse), .disc_q(queue_discard)
  );

  // an aborted transaction never reaches the local bus
  p_abort_no_start_r4: assert property (@(posedge clk) disable iff (rst)
    tgt_abort |-> !local_start);

  // address parity error always ends the phase in an abort
  p_ape_aborts_r4: assert property (@(posedge clk) disable iff (rst)
    (adr_vld && adr_par_err) |=> tgt_abort);

endmodule

// File: tb/pci_terr_ctrl_test.sv
`timescale 1ns/1ps
module pci_terr_ctrl_test;

  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst, cmd_pen, cmd_sen, pe_wr1c, dpar_err;
  logic adr_vld, adr_write, adr_delayed, adr_retry, adr_par_err, rng_bad;
  logic [SW-1:0] adr_slot;
  logic seg_vld, seg_bad, seg_last;
  logic pe_status, perr_pulse, serr_pulse, tgt_abort, local_start, queue_discard;

  always #2 clk = ~clk;

  pci_terr_ctrl #(.NUM_SLOTS(NS)) uut (
    .clk(clk), .rst(rst), .cmd_pen(cmd_pen), .cmd_sen(cmd_sen),
    .pe_wr1c(pe_wr1c), .dpar_err(dpar_err), .adr_vld(adr_vld),
    .adr_write(adr_write), .adr_delayed(adr_delayed), .adr_retry(adr_retry),
    .adr_slot(adr_slot), .adr_par_err(adr_par_err), .rng_bad(rng_bad),
    .seg_vld(seg_vld), .seg_bad(seg_bad), .seg_last(seg_last),
    .pe_status(pe_status), .perr_pulse(perr_pulse), .serr_pulse(serr_pulse),
    .tgt_abort(tgt_abort), .local_start(local_start), .queue_discard(queue_discard)
  );

  // expected word: {abort, start, pe, perr, serr, discard}
  logic [5:0] exp_q[$];
  string      tag_q[$];
  int n_cmp = 0, n_bad = 0;
  logic [NS-1:0] m_pend;
  logic m_pe;
  bit done = 0;

  // Driver: one cycle of stimulus plus the model's prediction.
  task automatic cyc(input logic r, input logic clr, input logic dpe,
                     input logic av, input logic aw, input logic ad, input logic ar,
                     input int slot, input logic ape, input logic rb,
                     input logic sv, input logic sb, input logic sl, input string tag);
    logic ab, st, pr, se, di;
    @(negedge clk);
    rst = r; pe_wr1c = clr; dpar_err = dpe;
    adr_vld = av; adr_write = aw; adr_delayed = ad; adr_retry = ar;
    adr_slot = SW'(slot); adr_par_err = ape; rng_bad = rb;
    seg_vld = sv; seg_bad = sb; seg_last = sl;
    ab = 0; st = 0; pr = 0; se = 0; di = 0;
    if (r) begin
      m_pend = '0; m_pe = 0;
    end else begin
      pr = dpe & cmd_pen;
      if (dpe) m_pe = 1; else if (clr) m_pe = 0;
      if (av) begin
        if (ape) ab = 1;
        else if (ar) begin
          if (m_pend[slot]) begin ab = 1; m_pend[slot] = 0; end
        end else if (!aw && rb) begin
          if (ad) m_pend[slot] = 1; else ab = 1;
        end else st = 1;
      end
      se = sv & sb & cmd_sen & cmd_pen;
      di = sv & sb & ~sl;
    end
    exp_q.push_back({ab, st, m_pe, pr, se, di});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0,0,0, 0,0,0,0,0,0,0, 0,0,0, tag);
  endtask
  task automatic adr(input logic aw, input logic ad, input logic ar, input int slot,
                     input logic ape, input logic rb, input string tag);
    cyc(0,0,0, 1,aw,ad,ar,slot,ape,rb, 0,0,0, tag);
  endtask
  task automatic seg(input logic sb, input logic sl, input string tag);
    cyc(0,0,0, 0,0,0,0,0,0,0, 1,sb,sl, tag);
  endtask

  // Monitor: compare one word just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [5:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {tgt_abort, local_start, pe_status, perr_pulse, serr_pulse, queue_discard};
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual={ab,st,pe,perr,serr,disc}=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cmd_pen = 1; cmd_sen = 1;
    cyc(1,0,0, 0,0,0,0,0,0,0, 0,0,0, "R12 reset");
    cyc(1,0,0, 0,0,0,0,0,0,0, 0,0,0, "R12 reset");
    idle("R12 idle after reset");
    // parity status and PERR#
    cyc(0,0,1, 0,0,0,0,0,0,0, 0,0,0, "R1 R2 dpe with pen");
    idle("R1 sticky R2 single pulse");
    idle("R1 sticky");
    cyc(0,1,0, 0,0,0,0,0,0,0, 0,0,0, "R3 clear");
    @(negedge clk); cmd_pen = 0;
    cyc(0,0,1, 0,0,0,0,0,0,0, 0,0,0, "R2 dpe without pen");
    cyc(0,1,1, 0,0,0,0,0,0,0, 0,0,0, "R3 set beats clear");
    cyc(0,1,0, 0,0,0,0,0,0,0, 0,0,0, "R3 clear again");
    @(negedge clk); cmd_pen = 1;
    // address phase decisions
    adr(0,0,0,0,0,0, "R8 clean read");
    adr(1,0,0,0,0,1, "R8 write ignores rng_bad");
    idle("R8 start one cycle");
    adr(0,0,0,0,1,0, "R4 ape read");
    adr(1,0,0,0,1,0, "R4 ape write");
    adr(0,0,0,0,0,1, "R5 immediate read bad range");
    adr(0,1,0,2,0,1, "R6 delayed read deferred");
    adr(0,0,1,1,0,0, "R7 retry without pending");
    adr(0,0,1,2,0,0, "R6 retry delivers abort");
    adr(0,0,1,2,0,0, "R6 flag cleared");
    adr(0,1,0,3,0,1, "R6 delayed read slot3");
    adr(0,0,1,3,1,0, "R4 ape on retry");
    adr(0,0,1,3,0,0, "R6 slot3 still pending");
    // posted write segments
    seg(0,0, "R9 good segment");
    seg(1,0, "R9 R10 bad mid segment");
    seg(1,1, "R10 R11 bad last segment");
    idle("R11 pulses end");
    @(negedge clk); cmd_pen = 0;
    seg(1,0, "R9 no serr without pen");
    @(negedge clk); cmd_pen = 1; cmd_sen = 0;
    seg(1,0, "R9 no serr without sen");
    @(negedge clk); cmd_sen = 1;
    // reset clears pending flags
    adr(0,1,0,0,0,1, "R6 set slot0");
    cyc(1,0,0, 0,0,0,0,0,0,0, 0,0,0, "R12 reset mid run");
    adr(0,0,1,0,0,0, "R12 pending cleared by reset");
    idle("R12 quiet");
    idle("R12 quiet");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule